// File: doc/BRIEF.md
# Serial Audio Word Transmitter

This block shifts a stereo pair of parallel sample words out on a single serial data line. It generates no clocks of its own. An external bit clock, a left/right (channel) clock and a word clock set the timing, and all three are brought into the system clock domain through multi-flop synchronizers. Each sample word is 24 bits of two's-complement data, sent most significant bit first. A receiver can stop capturing after any number of leading bits and still hold a correctly aligned, truncated value.

A 2-bit framing selector picks where each word starts. The start can be at the channel clock transition, one bit period after it, sixteen bit periods after it (right-aligned placement), or at a rising edge of the word clock. A polarity input selects which bit-clock edge the receiver samples on, and data is launched on the other edge. A mute input forces the data line to zero.

The producer writes one stereo pair into a single-entry holding register through a valid/ready handshake. At each left-channel framing event that pair becomes the pair in transmission. If no new pair has arrived by then, the previous pair is sent again and an underrun flag is raised.

Top module: `ser_audio_tx`

## Requirements
- R1: Each channel word goes out MSB first, 24 bits long. The left word starts on a channel-clock falling edge (channel clock low) and the right word on a rising edge (channel clock high). Outside the 24 bit slots of a word, the data line is 0.
- R2: With framing code 0, the MSB is valid at the first receiving edge after the channel clock transition.
- R3: With framing code 1, the MSB is valid at the second receiving edge after the transition, which is one bit period later than with code 0.
- R4: With framing code 2, the MSB is valid at the receiving edge 16 bit periods after the transition (receiving edge index 16, counting from 0).
- R5: With framing code 3, channel-clock transitions start nothing. A word clock rising edge starts a word, and its MSB is valid at the first receiving edge from that point on. The channel clock level at that edge picks the channel: low for left, high for right.
- R6: With polarity 0 the receiver samples on rising bit-clock edges and data changes after falling edges. With polarity 1 both roles are swapped.
- R7: The bit clock may stop for any length of time. Pauses neither drop nor repeat bits.
- R8: While mute is high, the data line is 0 from the next system clock cycle on.
- R9: `smp_ready` is high exactly when the holding register is empty. A pair is taken on a cycle with both valid and ready high. Ready then stays low until the next left framing event moves the pair into transmission.
- R10: A left framing event that finds the holding register empty resends the previous pair and sets `underrun`. The flag clears at the first left framing event that finds a new pair.
- R11: After reset, the data line is 0, `smp_ready` is 1, `underrun` is 0 and the stored pair is all zeros.
- R12: The data line changes only in the system clock cycle after a launch edge, a framing event or a change of mute. It reacts to an external edge within SYNC_STAGES+2 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bclk_in | input | 1 | External bit clock, may be gated |
| lrclk_in | input | 1 | External channel clock, low = left |
| wclk_in | input | 1 | External word clock, used in framing code 3 |
| fmt_sel | input | 2 | Framing code 0..3 |
| bclk_pol | input | 1 | Receiving edge select: 0 = rising, 1 = falling |
| mute | input | 1 | Forces the data line to zero |
| smp_valid | input | 1 | Producer has a stereo pair |
| smp_ready | output | 1 | Holding register empty |
| smp_left | input | 24 | Left sample word |
| smp_right | input | 24 | Right sample word |
| sdata_out | output | 1 | Serial data line |
| underrun | output | 1 | Previous pair was resent |

## Verification
The assertions check four things on every cycle. Mute must force zero data. Ready must fall after an accepted pair. The underrun flag must be set or cleared at every left framing event, according to whether the holding register was full. The data line must stay quiet when there is no launch edge, framing event or mute change. Only the bench scenarios can show the bit placement itself: the MSB offsets of the four framing codes, the swap of edges under either polarity, the survival of bit order across bit-clock pauses, and the resend of an old pair after a skipped load. The bench does this by acting as a receiver and comparing each captured bit with a computed word.

// File: rtl/stx_pkg.sv
package stx_pkg;

   typedef enum logic [1:0] {
      FMT_EDGE    = 2'd0,
      FMT_EDGE_D1 = 2'd1,
      FMT_RALIGN  = 2'd2,
      FMT_WORDCLK = 2'd3
   } fmt_e;

   localparam int IDX_BCLK = 0;
   localparam int IDX_LR   = 1;
   localparam int IDX_WCLK = 2;
   localparam int N_EXT    = 3;

   // number of launch edges between the framing event and the MSB
   function automatic int fmt_delay(fmt_e f, int ralign_dly);
      case (f)
         FMT_EDGE_D1: return 1;
         FMT_RALIGN:  return ralign_dly;
         default:     return 0;
      endcase
   endfunction

endpackage

// File: rtl/stx_edge_sync.sv
module stx_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic lvl,
   output logic prv
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("stx_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], async_in};
   end

   assign lvl = chain[STAGES-1];
   assign prv = chain[STAGES];
endmodule

// File: rtl/stx_frame_ctl.sv
module stx_frame_ctl
   import stx_pkg::*;
(
   input  fmt_e             fmt,
   input  logic             pol,
   input  logic [N_EXT-1:0] lvl,
   input  logic [N_EXT-1:0] prv,
   output logic             launch_ev,
   output logic             frame_ev,
   output logic             frame_right
);
   logic [N_EXT-1:0] rise, fall;

   assign rise = lvl & ~prv;
   assign fall = ~lvl & prv;

   // receiver samples on rising edge when pol=0, so we launch on falling
   assign launch_ev   = pol ? rise[IDX_BCLK] : fall[IDX_BCLK];
   assign frame_ev    = (fmt == FMT_WORDCLK) ? rise[IDX_WCLK]
                                             : (rise[IDX_LR] | fall[IDX_LR]);
   assign frame_right = lvl[IDX_LR];
endmodule

// File: rtl/stx_sample_buf.sv
module stx_sample_buf #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_left,
   input  logic [W-1:0] in_right,
   input  logic         take,
   output logic [W-1:0] cur_left,
   output logic [W-1:0] cur_right,
   output logic         underrun
);
   logic [W-1:0] hold_l, hold_r, act_l, act_r;
   logic         full, urun_q;

   assign in_ready  = ~full;
   assign cur_left  = (take && full) ? hold_l : act_l;
   assign cur_right = (take && full) ? hold_r : act_r;
   assign underrun  = urun_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l <= '0;
         hold_r <= '0;
         act_l  <= '0;
         act_r  <= '0;
         full   <= 1'b0;
         urun_q <= 1'b0;
      end else begin
         if (take) begin
            act_l  <= cur_left;
            act_r  <= cur_right;
            urun_q <= ~full;
            full   <= 1'b0;
         end
         if (in_valid && ~full) begin
            hold_l <= in_left;
            hold_r <= in_right;
            full   <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
   import stx_pkg::*;
#(
   parameter int W          = 24,
   parameter int RALIGN_DLY = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  fmt_e         fmt,
   input  logic         frame_ev,
   input  logic         launch_ev,
   input  logic [W-1:0] word,
   input  logic         mute,
   output logic         sdata
);
   localparam int CMAX = (W > RALIGN_DLY) ? W : RALIGN_DLY;
   localparam int CW   = $clog2(CMAX + 1);

   logic [W-1:0]  sh_q, sh_n;
   logic [CW-1:0] skip_q, skip_n, left_q, left_n, dly;
   logic          sd_q, sd_n;

   assign dly = CW'(fmt_delay(fmt, RALIGN_DLY));

   always_comb begin
      sh_n   = sh_q;
      skip_n = skip_q;
      left_n = left_q;
      if (frame_ev) begin
         sh_n   = word;
         skip_n = dly;
         left_n = (dly == '0) ? CW'(W) : '0;
      end else if (launch_ev) begin
         if (skip_q != '0) begin
            skip_n = skip_q - 1'b1;
            if (skip_q == CW'(1)) left_n = CW'(W);
         end else if (left_q != '0) begin
            sh_n   = {sh_q[W-2:0], 1'b0};
            left_n = left_q - 1'b1;
         end
      end
      sd_n = ~mute && (left_n != '0) && sh_n[W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         skip_q <= '0;
         left_q <= '0;
         sd_q   <= 1'b0;
      end else begin
         sh_q   <= sh_n;
         skip_q <= skip_n;
         left_q <= left_n;
         sd_q   <= sd_n;
      end
   end

   assign sdata = sd_q;
endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx
   import stx_pkg::*;
#(
   parameter int SMP_W       = 24,
   parameter int RALIGN_DLY  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_in,
   input  logic             lrclk_in,
   input  logic             wclk_in,
   input  logic [1:0]       fmt_sel,
   input  logic             bclk_pol,
   input  logic             mute,
   input  logic             smp_valid,
   output logic             smp_ready,
   input  logic [SMP_W-1:0] smp_left,
   input  logic [SMP_W-1:0] smp_right,
   output logic             sdata_out,
   output logic             underrun
);
   generate
      if (SMP_W < 4) begin : g_bad_width
         $error("ser_audio_tx: SMP_W must be at least 4");
      end
      if (RALIGN_DLY < 1) begin : g_bad_dly
         $error("ser_audio_tx: RALIGN_DLY must be at least 1");
      end
   endgenerate

   logic [N_EXT-1:0] ext_raw, ext_lvl, ext_prv;
   logic             launch_ev, frame_ev, frame_right;
   logic [SMP_W-1:0] cur_l, cur_r, word;
   fmt_e             fmt;

   assign fmt = fmt_e'(fmt_sel);

   always_comb begin
      ext_raw           = '0;
      ext_raw[IDX_BCLK] = bclk_in;
      ext_raw[IDX_LR]   = lrclk_in;
      ext_raw[IDX_WCLK] = wclk_in;
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_EXT; gi++) begin : g_sync
         stx_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_in(ext_raw[gi]),
            .lvl     (ext_lvl[gi]),
            .prv     (ext_prv[gi])
         );
      end
   endgenerate

   stx_frame_ctl i_frame (
      .fmt        (fmt),
      .pol        (bclk_pol),
      .lvl        (ext_lvl),
      .prv        (ext_prv),
      .launch_ev  (launch_ev),
      .frame_ev   (frame_ev),
      .frame_right(frame_right)
   );

   stx_sample_buf #(.W(SMP_W)) i_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (smp_valid),
      .in_ready (smp_ready),
      .in_left  (smp_left),
      .in_right (smp_right),
      .take     (frame_ev & ~frame_right),
      .cur_left (cur_l),
      .cur_right(cur_r),
      .underrun (underrun)
   );

   assign word = frame_right ? cur_r : cur_l;

   stx_shifter #(.W(SMP_W), .RALIGN_DLY(RALIGN_DLY)) i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .fmt      (fmt),
      .frame_ev (frame_ev),
      .launch_ev(launch_ev),
      .word     (word),
      .mute     (mute),
      .sdata    (sdata_out)
   );
endmodule

// File: rtl/stx_tx_checker.sv
module stx_tx_checker (
   input logic clk,
   input logic rst_n,
   input logic mute,
   input logic sdata_out,
   input logic smp_valid,
   input logic smp_ready,
   input logic underrun,
   input logic launch_ev,
   input logic frame_ev,
   input logic frame_right
);
   // R8: mute forces a zero line on the next cycle
   assert_mute_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mute |=> !sdata_out);

   // R9: an accepted pair makes the holding register busy
   assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_ready) |=> !smp_ready);

   // R10: empty holding register at a left framing event raises underrun
   assert_underrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ev && !frame_right && smp_ready) |=> underrun);

   // R10: a full holding register at a left framing event clears underrun
   assert_underrun_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ev && !frame_right && !smp_ready) |=> !underrun);

   // R12: no event and steady mute keeps the line unchanged
   assert_line_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch_ev && !frame_ev && $stable(mute)) |=> $stable(sdata_out));
endmodule

bind ser_audio_tx stx_tx_checker i_tx_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mute       (mute),
   .sdata_out  (sdata_out),
   .smp_valid  (smp_valid),
   .smp_ready  (smp_ready),
   .underrun   (underrun),
   .launch_ev  (launch_ev),
   .frame_ev   (frame_ev),
   .frame_right(frame_right)
);

// File: tb/test_ser_audio_tx.sv
module test_ser_audio_tx;
   localparam int W    = 24;
   localparam int DRJ  = 16;
   localparam int H    = 8;
   localparam int NBIT = 48;
   localparam int WOFS = 3;

   logic         clk = 1'b0;
   logic         rst_n, bclk, lrclk, wclk, pol, mute, valid;
   logic [1:0]   fmt;
   logic [W-1:0] left_w, right_w;
   logic         ready, sdata, urun;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   logic [W-1:0] prev_l = '0, prev_r = '0;

   always #5 clk = ~clk;

   ser_audio_tx i_ser_audio_tx (
      .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .lrclk_in(lrclk), .wclk_in(wclk),
      .fmt_sel(fmt), .bclk_pol(pol), .mute(mute), .smp_valid(valid),
      .smp_ready(ready), .smp_left(left_w), .smp_right(right_w),
      .sdata_out(sdata), .underrun(urun)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic exp_bit(input logic [W-1:0] w, input int k, input int d);
      if (k >= d && k < d + W) return w[W-1-(k-d)];
      return 1'b0;
   endfunction

   task automatic push(input logic [W-1:0] l, input logic [W-1:0] r);
      @(negedge clk);
      while (!ready) @(negedge clk);
      valid = 1'b1; left_w = l; right_w = r;
      @(negedge clk);
      valid = 1'b0;
      chk(ready == 1'b0, "R9", "ready after load", ready, 0);
   endtask

   // acts as the receiver: one frame = left half then right half
   task automatic run_frame(input int md, input bit pl, input logic [W-1:0] l,
                            input logic [W-1:0] r, input bit mu, input bit gaps);
      fmt = 2'(md); pol = pl; mute = mu; bclk = ~pl;
      repeat (4) @(negedge clk);
      for (int ch = 0; ch < 2; ch++) begin
         logic [W-1:0] w;
         int d;
         w = (ch == 1) ? r : l;
         d = (md == 1) ? 1 : (md == 2) ? DRJ : (md == 3) ? WOFS : 0;
         for (int k = 0; k < NBIT; k++) begin
            string tag;
            logic  e;
            bclk = pl;                       // launch edge
            if (k == 0) lrclk = ch[0];
            if (md == 3 && k == WOFS) wclk = 1'b1;
            if (k == WOFS + 8) wclk = 1'b0;
            repeat (H) @(negedge clk);
            if (gaps && $urandom_range(0, 3) == 0)
               repeat ($urandom_range(1, 20)) @(negedge clk);
            e = mu ? 1'b0 : exp_bit(w, k, d);
            if (mu) tag = "R8";
            else if (k < d || k >= d + W) tag = "R1";
            else case (md)
               0: tag = "R2";
               1: tag = "R3";
               2: tag = "R4";
               default: tag = "R5";
            endcase
            if (pl)   tag = {tag, "+R6"};
            if (gaps) tag = {tag, "+R7"};
            chk(sdata == e, tag, $sformatf("ch%0d bit slot %0d", ch, k), sdata, e);
            bclk = ~pl;                      // receiving edge
            repeat (H) @(negedge clk);
         end
      end
   endtask

   task automatic frame_with(input int md, input bit pl, input bit mu, input bit gaps,
                             input bit do_push, input logic [W-1:0] l, input logic [W-1:0] r);
      logic [W-1:0] el, er;
      if (do_push) begin push(l, r); el = l; er = r; end
      else begin el = prev_l; er = prev_r; end
      run_frame(md, pl, el, er, mu, gaps);
      prev_l = el; prev_r = er;
      chk(urun == !do_push, "R10", "underrun flag", urun, !do_push);
      chk(ready == 1'b1, "R9", "ready after frame", ready, 1);
   endtask

   initial begin
      void'($urandom(32'h1A2B_3C4D));
      rst_n = 1'b0; bclk = 1'b1; lrclk = 1'b1; wclk = 1'b0; pol = 1'b0;
      mute = 1'b0; valid = 1'b0; fmt = 2'd0; left_w = '0; right_w = '0;
      repeat (5) @(negedge clk);
      chk(sdata == 1'b0, "R11", "data in reset", sdata, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(sdata == 1'b0, "R11", "data after reset", sdata, 0);
      chk(ready == 1'b1, "R11", "ready after reset", ready, 1);
      chk(urun == 1'b0,  "R11", "underrun after reset", urun, 0);

      // directed corners
      frame_with(0, 0, 0, 0, 1, 24'h800001, 24'h7FFFFE);
      frame_with(1, 0, 0, 0, 1, 24'hA5A5A5, 24'h5A5A5A);
      frame_with(2, 0, 0, 0, 1, 24'hFFFFFF, 24'hC00003);
      frame_with(3, 0, 0, 0, 1, 24'h123456, 24'hFEDCBA);
      frame_with(0, 1, 0, 0, 1, 24'h0F0F0F, 24'hF0F0F0);
      frame_with(3, 1, 0, 1, 1, 24'h96C3E1, 24'h3C3C3C);
      frame_with(2, 1, 0, 1, 1, 24'h800000, 24'h000001);
      frame_with(0, 0, 1, 0, 1, 24'hFFFFFF, 24'hFFFFFF);   // mute, R8
      frame_with(1, 0, 0, 0, 0, 24'h0, 24'h0);             // underrun resend, R10
      frame_with(0, 0, 0, 0, 1, 24'h13579B, 24'h2468AC);   // clears R10

      // constrained random
      for (int i = 0; i < 12; i++) begin
         frame_with($urandom_range(0, 3), $urandom_range(0, 1),
                    ($urandom_range(0, 5) == 0), $urandom_range(0, 1),
                    ($urandom_range(0, 4) != 0),
                    W'($urandom), W'($urandom));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule